// File: doc/BRIEF.md
# Debug Port Status-Capturing Instruction Register

This block is the instruction register of a serial, JTAG-style debug port. It does not load the usual fixed capture pattern. When the test access state machine reports the Capture-IR state, the register loads a ten-bit snapshot of processor status. During Shift-IR it sends that snapshot out on the serial output, least-significant bit first. At the same time it takes new command bits from the serial input into its top end. When Update-IR is reported, the accumulated bits are transferred to a parallel command word for a downstream decoder.

The status lines come from the processor and are first sampled by one flip-flop stage on the test clock. The capture word places these fields at bits 0 to 7: clock-on, single-step error, checkstop, reset, halted, stopped, debug mode and waiting. Every field except reset carries the level of its line. The reset field carries the inverse of the active-low reset line.

The debug-mode field follows the processor's debug state as a level. It reads 0 again as soon as the processor leaves debug mode, even in the middle of a debug session. The two top bits are fixed at 0 (bit 8) and 1 (bit 9) so that the capture stays standards-compliant.

A debug-enable input gates all activity. While it is low, the shift stage and the command word keep their values and the serial output stays low. The state machine and the command decoder are outside this block.

Top module: `dbg_ir`

## Requirements
- R1: While `rst_n` is sampled low on a rising `tck` edge, the shift stage and `cmd` are cleared to 0. `tdo` is driven to 0 at the following falling edge.
- R2: A rising edge with `cap_ir` and `dbg_en` high loads status into the shift stage. The layout is bit0 `clk_on`, bit1 `step_err`, bit2 `chkstop`, bit3 reset field, bit4 `halted`, bit5 `stopped`, bit6 `in_debug`, bit7 `waiting`.
- R3: The captured reset field (bit 3) equals the inverse of `core_rst_n`.
- R4: Every capture loads bit 8 as 0 and bit 9 as 1.
- R5: On a rising edge with `shf_ir` and `dbg_en` high and `cap_ir` low, the shift stage moves one place toward bit 0 and `tdi` enters bit 9. `tdo` shows shift-stage bit 0 from the next falling edge, so captured bit 0 leaves first. After ten shifts the stage holds the ten `tdi` bits, with the first bit sent at bit 0.
- R6: `cmd` takes the shift-stage value only on a rising edge with `upd_ir` and `dbg_en` high. At all other times it holds its value.
- R7: While `dbg_en` is low, `tdo` is 0, and the shift stage and `cmd` keep their values whatever `cap_ir`, `shf_ir`, `upd_ir` and `tdi` do.
- R8: `tdo` is 0 at every falling edge where `shf_ir` is low.
- R9: The debug-mode field reflects the current `in_debug` level. A capture taken after the processor leaves debug mode reads 0 there.
- R10: Status inputs pass through one `tck` sampling stage. A capture loads the levels sampled at the rising edge before the capture edge, not levels that change only one cycle before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low test reset |
| cap_ir | input | 1 | Capture-IR state strobe |
| shf_ir | input | 1 | Shift-IR state strobe |
| upd_ir | input | 1 | Update-IR state strobe |
| tdi | input | 1 | Serial data input |
| dbg_en | input | 1 | Debug operation enable |
| clk_on | input | 1 | Processor clock-running status |
| step_err | input | 1 | Interrupt hit during last single-stepped instruction |
| chkstop | input | 1 | Processor checkstop status |
| core_rst_n | input | 1 | Processor reset, active low |
| halted | input | 1 | Processor halted status |
| stopped | input | 1 | Processor stopped status |
| in_debug | input | 1 | Processor is in debug mode |
| waiting | input | 1 | Processor waiting status |
| tdo | output | 1 | Serial data output, changes on falling `tck` |
| cmd | output | 10 | Parallel command word |

## Verification
Freezing the register is the hardest case to set up from the ports. It needs a capture that has not yet been shifted out, followed by disabled cycles that toggle the shift and update strobes. The bench captures a known word and then drops `dbg_en` while pulsing `shf_ir`, `upd_ir` and random `tdi` bits. It re-enables and shifts all ten bits out, so any disturbance shows up as a wrong serial bit or a changed `cmd`. The sampling delay is reached by changing the status lines in the same cycle the capture strobe is raised. The capture must then still show the older levels.

// File: rtl/dbg_ir_pkg.sv
// Package: widths and bit positions of the status-capturing instruction register.
// Assumes: the field positions are fixed because the command decoder and the
// debugger software read the capture word at these bits.
package dbg_ir_pkg;
    localparam int IR_W   = 10;
    localparam int STAT_W = 8;
    localparam int POS_RST = 3;
    localparam logic [IR_W-STAT_W-1:0] TOP_BITS = 2'b10;
    localparam logic [IR_W-1:0] IDLE_CMD = '0;
endpackage

// File: rtl/dbg_ir_status_sample.sv
// Module: samples the raw processor status lines on tck and forms the
// eight-bit status field, inverting the active-low reset line.
// Assumes: status lines are quasi-static relative to tck.
module dbg_ir_status_sample
    import dbg_ir_pkg::*;
(
    input  logic              tck,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] raw,
    output logic [STAT_W-1:0] stat
);
    localparam logic [STAT_W-1:0] INV_MASK = STAT_W'(1) << POS_RST;

    // one sampling flop per line; the reset field is stored inverted
    always_ff @(posedge tck) begin
        if (!rst_n) stat <= '0;
        else        stat <= raw ^ INV_MASK;
    end
endmodule

// File: rtl/dbg_ir_shift.sv
// Module: the shift stage. Capture loads fixed top bits above the status
// field. Shift moves toward bit 0, with tdi entering the top bit.
// Assumes: capture wins if capture and shift are both strobed; enable gates all.
module dbg_ir_shift
    import dbg_ir_pkg::*;
(
    input  logic              tck,
    input  logic              rst_n,
    input  logic              en,
    input  logic              cap,
    input  logic              shf,
    input  logic              tdi,
    input  logic [STAT_W-1:0] stat,
    output logic [IR_W-1:0]   sreg
);
    // load status, shift serial data, or hold
    always_ff @(posedge tck) begin
        if (!rst_n)          sreg <= '0;
        else if (en && cap)  sreg <= {TOP_BITS, stat};
        else if (en && shf)  sreg <= {tdi, sreg[IR_W-1:1]};
    end
endmodule

// File: rtl/dbg_ir_out.sv
// Module: output side. Holds the parallel command word, updated on
// Update-IR. Drives tdo from bit 0 of the shift stage on the falling edge.
// Assumes: strobes are stable around the falling edge of tck.
module dbg_ir_out
    import dbg_ir_pkg::*;
(
    input  logic            tck,
    input  logic            rst_n,
    input  logic            en,
    input  logic            upd,
    input  logic            shf,
    input  logic [IR_W-1:0] sreg,
    output logic [IR_W-1:0] cmd,
    output logic            tdo
);
    // command word transfer on update
    always_ff @(posedge tck) begin
        if (!rst_n)         cmd <= IDLE_CMD;
        else if (en && upd) cmd <= sreg;
    end

    // serial output launched on the falling edge, quiet unless shifting
    always_ff @(negedge tck) begin
        if (!rst_n) tdo <= 1'b0;
        else        tdo <= en & shf & sreg[0];
    end
endmodule

// File: rtl/dbg_ir.sv
// Module: top of the status-capturing debug instruction register.
// Assumes: TAP state strobes come from an external state machine on tck.
module dbg_ir
    import dbg_ir_pkg::*;
(
    input  logic            tck,
    input  logic            rst_n,
    input  logic            cap_ir,
    input  logic            shf_ir,
    input  logic            upd_ir,
    input  logic            tdi,
    input  logic            dbg_en,
    input  logic            clk_on,
    input  logic            step_err,
    input  logic            chkstop,
    input  logic            core_rst_n,
    input  logic            halted,
    input  logic            stopped,
    input  logic            in_debug,
    input  logic            waiting,
    output logic            tdo,
    output logic [IR_W-1:0] cmd
);
    logic [STAT_W-1:0] raw_stat;
    logic [STAT_W-1:0] stat;
    logic [IR_W-1:0]   shift_q;

    assign raw_stat = {waiting, in_debug, stopped, halted,
                       core_rst_n, chkstop, step_err, clk_on};

    dbg_ir_status_sample u_samp (
        .tck(tck), .rst_n(rst_n), .raw(raw_stat), .stat(stat)
    );

    dbg_ir_shift u_shift (
        .tck(tck), .rst_n(rst_n), .en(dbg_en), .cap(cap_ir), .shf(shf_ir),
        .tdi(tdi), .stat(stat), .sreg(shift_q)
    );

    dbg_ir_out u_out (
        .tck(tck), .rst_n(rst_n), .en(dbg_en), .upd(upd_ir), .shf(shf_ir),
        .sreg(shift_q), .cmd(cmd), .tdo(tdo)
    );
endmodule

// File: rtl/dbg_ir_checker.sv
// Module: property checker for dbg_ir, attached with bind.
// Assumes: strobes change only after the rising edge of tck.
module dbg_ir_checker
    import dbg_ir_pkg::*;
(
    input logic            tck,
    input logic            rst_n,
    input logic            cap_ir,
    input logic            shf_ir,
    input logic            upd_ir,
    input logic            tdi,
    input logic            dbg_en,
    input logic            tdo,
    input logic [IR_W-1:0] cmd,
    input logic [IR_W-1:0] shift_q
);
    AST_CMD_HOLD: assert property (@(posedge tck) disable iff (!rst_n)
        !(upd_ir && dbg_en) |=> $stable(cmd)); // R6
    AST_TOP_BITS: assert property (@(posedge tck) disable iff (!rst_n)
        (cap_ir && dbg_en) |=> (shift_q[IR_W-1:IR_W-2] == 2'b10)); // R4
    AST_SHIFT_IN: assert property (@(posedge tck) disable iff (!rst_n)
        (shf_ir && dbg_en && !cap_ir) |=> (shift_q[IR_W-1] == $past(tdi))); // R5
    AST_FROZEN: assert property (@(posedge tck) disable iff (!rst_n)
        !dbg_en |=> ($stable(shift_q) && $stable(cmd))); // R7
    AST_TDO_QUIET: assert property (@(posedge tck) disable iff (!rst_n)
        (!dbg_en || !shf_ir) |-> !tdo); // R8
endmodule

bind dbg_ir dbg_ir_checker u_chk (
    .tck(tck), .rst_n(rst_n), .cap_ir(cap_ir), .shf_ir(shf_ir),
    .upd_ir(upd_ir), .tdi(tdi), .dbg_en(dbg_en), .tdo(tdo), .cmd(cmd),
    .shift_q(shift_q)
);

// File: tb/dbg_ir_test.sv
module dbg_ir_test;
    logic tck = 1'b0;
    logic rst_n = 1'b0;
    logic cap_ir = 0, shf_ir = 0, upd_ir = 0, tdi = 0, dbg_en = 0;
    logic [7:0] raw = 8'h08;   // bit3 is the active-low core reset line
    logic tdo;
    logic [9:0] cmd;

    int tests = 0;
    int fails = 0;
    bit done = 0;
    bit mon_on = 0;
    logic [9:0] model = '0;

    typedef struct { logic b; string tag; } exp_t;
    exp_t q[$];

    always #5 tck = ~tck;

    dbg_ir uut (
        .tck(tck), .rst_n(rst_n), .cap_ir(cap_ir), .shf_ir(shf_ir),
        .upd_ir(upd_ir), .tdi(tdi), .dbg_en(dbg_en),
        .clk_on(raw[0]), .step_err(raw[1]), .chkstop(raw[2]),
        .core_rst_n(raw[3]), .halted(raw[4]), .stopped(raw[5]),
        .in_debug(raw[6]), .waiting(raw[7]), .tdo(tdo), .cmd(cmd)
    );

    task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected serial bit per enabled shift edge
    always @(posedge tck) begin
        if (mon_on) begin
            if (q.size() == 0) check("R5 queue empty", 10'(tdo), 10'h3ff);
            else begin
                exp_t e;
                e = q.pop_front();
                check(e.tag, 10'(tdo), 10'(e.b));
            end
        end
    end

    task automatic step();
        @(posedge tck); #2;
    endtask

    function automatic logic [9:0] cap_word(input logic [7:0] r);
        return {2'b10, r ^ 8'h08};
    endfunction

    task automatic set_stat(input logic [7:0] r);
        raw = r; step(); step();
    endtask

    task automatic capture(input logic [9:0] expw);
        cap_ir = 1; step(); cap_ir = 0;
        model = expw;
        check("R8 tdo low outside shift", 10'(tdo), 10'h0);
    endtask

    task automatic shift_n(input int n, input logic [9:0] din, input string tag);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.b = model[0];
            e.tag = (i == 3) ? {tag, " R3"} : (i >= 8) ? {tag, " R4"} : tag;
            q.push_back(e);
            tdi = din[i]; shf_ir = 1; mon_on = 1;
            step();
            model = {din[i], model[9:1]};
        end
        shf_ir = 0; mon_on = 0; tdi = 0;
    endtask

    task automatic update();
        upd_ir = 1; step(); upd_ir = 0;
    endtask

    task automatic frame(input logic [7:0] r, input logic [9:0] din, input string tag);
        set_stat(r);
        capture(cap_word(r));
        shift_n(10, din, tag);
        check("R6 cmd before update", cmd, cmd_prev);
        update();
        check("R5 cmd after update", cmd, din);
        cmd_prev = din;
    endtask

    logic [9:0] cmd_prev = '0;

    initial begin
        step(); step();
        check("R1 cmd in reset", cmd, 10'h0);
        check("R1 tdo in reset", 10'(tdo), 10'h0);
        rst_n = 1; dbg_en = 1;
        step();

        frame(8'hA5, 10'h2C3, "R2 pattern A5");
        frame(8'h5A, 10'h155, "R2 pattern 5A");
        frame(8'h00, 10'h3FF, "R2 all low");
        frame(8'hFF, 10'h001, "R2 all high");
        frame(8'h40, 10'h200, "R9 in debug");
        frame(8'h00, 10'h0F0, "R9 left debug");

        // R10: status changes in the cycle capture is raised
        set_stat(8'h13);
        raw = 8'hEC; cap_ir = 1; step(); cap_ir = 0;
        model = cap_word(8'h13);
        shift_n(10, 10'h000, "R10 sampling stage");
        update();
        check("R10 cmd", cmd, 10'h000);
        cmd_prev = 10'h000;

        // R7: freeze while disabled
        set_stat(8'h96);
        capture(cap_word(8'h96));
        dbg_en = 0;
        for (int i = 0; i < 4; i++) begin
            shf_ir = 1; tdi = i[0]; upd_ir = (i == 2); cap_ir = (i == 3);
            step();
            check("R7 tdo low when disabled", 10'(tdo), 10'h0);
        end
        shf_ir = 0; upd_ir = 0; cap_ir = 0; tdi = 0;
        step();
        check("R7 cmd held when disabled", cmd, cmd_prev);
        dbg_en = 1;
        shift_n(10, 10'h3A5, "R7 frozen capture");
        update();
        check("R7 cmd after re-enable", cmd, 10'h3A5);

        // R1: mid-run reset clears command
        rst_n = 0; step(); step();
        check("R1 cmd after reset", cmd, 10'h0);
        check("R1 tdo after reset", 10'(tdo), 10'h0);
        rst_n = 1; step();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule